// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control plane for a bank of DMA channels. A simple single-cycle register bus reaches three global words: a control word that gates channel clocks, requests channel resets and turns on burst modes; a completion word that holds sticky per-channel done flags beside their interrupt enables; and an error word that holds sticky per-channel error flags. Each global word answers at three addresses. The base address replaces the word, base+4 ORs the written ones into it and base+8 clears the written ones. A read of any of the three addresses returns the word.

The channel datapaths sit outside the block and connect through pulses and levels. They report completion and errors as one-cycle pulses. They consume a one-cycle reset pulse, a clock-stop level, a run level and a next-command address. Each channel has two registers at a fixed stride. One holds the address of the next command. The other is a command credit counter: software writes add to it, and decrement pulses from the channel lower it. The channel runs while the count is nonzero. A single interrupt output combines the enabled completion flags and all error flags.

The default build has 8 channels. The control word places channel fields at bit 8+n and bit 16+n, so at most 8 channels fit.

Top module: `dmac_ctrl_regs`

## Requirements
- R1: After reset, every register reads 0, `bus_rdata` is 0, and `irq`, `ch_gate`, `ch_rst`, `ch_run`, `burst_en`, `burst8_en` and `ch_next_addr` are all 0.
- R2: Each of the global words at 0x000, 0x010 and 0x020 behaves as follows. A write at base+0 replaces the word. A write at base+4 ORs the data into it. A write at base+8 clears the bits written as 1. A read at base+0, base+4 or base+8 returns the word.
- R3: In the control word at 0x000, bit 29 drives `burst8_en` and bit 28 drives `burst_en`. Bit 8+n drives `ch_gate[n]`, where 1 stops channel n. Bits with no function read 0.
- R4: Writing 1 to bit 16+n of the control word raises `ch_rst[n]` in the cycle after the write, for exactly one cycle. After that the bit reads back 0.
- R5: A `ch_done[n]` pulse sets bit n of the completion word at 0x010. The bit stays set until software clears it. If the pulse and a clear of that bit land in the same cycle, the bit ends up set. Bit 16+n of the same word is the interrupt enable for channel n.
- R6: A `ch_err[n]` pulse sets bit n of the error word at 0x020. Software clears the bit, and a pulse that coincides with the clear wins.
- R7: `irq` is 1 exactly when some channel n has both completion bit n and enable bit 16+n set, or any error bit is set. It follows a status pulse by one cycle.
- R8: The next-command address of channel n is a 32-bit read/write register at 0x050 + 0x70·n. It drives `ch_next_addr[32n+31:32n]`.
- R9: The credit counter of channel n is at 0x080 + 0x70·n. A write adds `bus_wdata[23:16]`. A `ch_dec[n]` pulse subtracts 1 but never goes below 0. A write and a decrement in the same cycle give count+add−1. The count saturates at 255. A read returns the count in bits 23:16. `ch_run[n]` is 1 while the count is nonzero.
- R10: Read data appears on `bus_rdata` in the cycle after a read access. An unmapped address reads 0. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ch_done | input | NCH | Per-channel completion pulses |
| ch_err | input | NCH | Per-channel error pulses |
| ch_dec | input | NCH | Per-channel credit decrement pulses |
| ch_gate | output | NCH | Per-channel clock stop |
| ch_rst | output | NCH | Per-channel one-cycle reset pulse |
| ch_run | output | NCH | Per-channel credit nonzero |
| ch_next_addr | output | 32·NCH | Per-channel next-command address |
| burst_en | output | 1 | Burst enable |
| burst8_en | output | 1 | 8-beat burst enable |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume a few things about the block's inputs. They assume every bus access lasts a single cycle. They assume that register changes seen on `ch_gate`, `ch_rst` and the rise of `ch_run` can only come from a bus write in the previous cycle. They judge the interrupt following a completion or error pulse only in cycles with no bus write, because a write in that cycle could legally turn the enable or flag off. The stimulus stays inside these assumptions. It changes inputs only on the falling edge, keeps every pulse and access to one cycle, and returns `bus_sel` to 0 between accesses.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    typedef enum logic [1:0] {OP_WR, OP_SET, OP_CLR} op_e;

    typedef enum logic [2:0] {G_NONE, G_C0, G_C1, G_C2, G_NXT, G_SEMA} grp_e;

    localparam int unsigned GLOBAL_STEP = 'h10;
    localparam int unsigned ALIAS_STEP  = 4;
    localparam int unsigned NXT_BASE    = 'h050;
    localparam int unsigned SEMA_BASE   = 'h080;
    localparam int unsigned CH_STRIDE   = 'h70;

    localparam int unsigned BIT_BURST8  = 29;
    localparam int unsigned BIT_BURST   = 28;
    localparam int unsigned GATE_LSB    = 8;
    localparam int unsigned RST_LSB     = 16;
    localparam int unsigned IEN_LSB     = 16;
    localparam int unsigned SEMA_LSB    = 16;

    function automatic logic [31:0] apply_op(op_e op, logic [31:0] cur, logic [31:0] wd);
        logic [31:0] r;
        case (op)
            OP_SET:  r = cur | wd;
            OP_CLR:  r = cur & ~wd;
            default: r = wd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dmac_addr_decode.sv
module dmac_addr_decode
    import dmac_regs_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 12,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0] addr,
    output grp_e          grp,
    output op_e           op,
    output logic [CW-1:0] chan
);

    always_comb begin
        grp  = G_NONE;
        op   = OP_WR;
        chan = '0;
        for (int g = 0; g < 3; g++) begin
            for (int a = 0; a < 3; a++) begin
                if (addr == AW'(g * GLOBAL_STEP + a * ALIAS_STEP)) begin
                    grp = grp_e'(3'(g + 1));
                    op  = op_e'(2'(a));
                end
            end
        end
        for (int n = 0; n < NCH; n++) begin
            if (addr == AW'(NXT_BASE + n * CH_STRIDE)) begin
                grp  = G_NXT;
                chan = CW'(n);
            end
            if (addr == AW'(SEMA_BASE + n * CH_STRIDE)) begin
                grp  = G_SEMA;
                chan = CW'(n);
            end
        end
    end

endmodule

// File: rtl/dmac_sema_cnt.sv
module dmac_sema_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         busy
);

    localparam logic [W:0] CNT_MAX = {1'b0, {W{1'b1}}};

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q};
        if (add_en) sum = sum + {1'b0, add_val};
        if (dec && (sum != '0)) sum = sum - 1'b1;
        if (sum > CNT_MAX) sum = CNT_MAX;
        cnt_d = sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign busy  = (cnt_q != '0);

endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_regs_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int AW     = 12,
    parameter int SEMA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    ch_done,
    input  logic [NCH-1:0]    ch_err,
    input  logic [NCH-1:0]    ch_dec,
    output logic [NCH-1:0]    ch_gate,
    output logic [NCH-1:0]    ch_rst,
    output logic [NCH-1:0]    ch_run,
    output logic [NCH*32-1:0] ch_next_addr,
    output logic              burst_en,
    output logic              burst8_en,
    output logic              irq
);

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [31:0] CH_MASK   = 32'((64'd1 << NCH) - 64'd1);
    localparam logic [31:0] RST_FIELD = CH_MASK << RST_LSB;
    localparam logic [31:0] C0_MASK   = (32'd1 << BIT_BURST8) | (32'd1 << BIT_BURST)
                                      | (CH_MASK << GATE_LSB) | RST_FIELD;
    localparam logic [31:0] C1_MASK   = CH_MASK | (CH_MASK << IEN_LSB);
    localparam logic [31:0] C2_MASK   = CH_MASK;

    typedef struct packed {
        logic [31:0]           ctl0;
        logic [31:0]           ctl1;
        logic [31:0]           ctl2;
        logic [31:0]           rdata;
        logic [NCH-1:0][31:0]  nxt;
    } state_t;

    state_t s_d, s_q;

    grp_e          grp;
    op_e           op;
    logic [CW-1:0] chan;
    logic          wr_go, rd_go;
    logic [NCH-1:0] irq_en_w;
    logic [SEMA_W-1:0] sema_cnt [NCH];

    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & ~bus_wr;

    dmac_addr_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr (bus_addr),
        .grp  (grp),
        .op   (op),
        .chan (chan)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_sema
        dmac_sema_cnt #(.W(SEMA_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (wr_go && (grp == G_SEMA) && (chan == CW'(n))),
            .add_val (bus_wdata[SEMA_LSB +: SEMA_W]),
            .dec     (ch_dec[n]),
            .count   (sema_cnt[n]),
            .busy    (ch_run[n])
        );
    end

    always_comb begin
        logic [31:0] base0;
        logic [31:0] c1;
        logic [31:0] c2;

        s_d = s_q;

        base0 = s_q.ctl0 & ~RST_FIELD;
        s_d.ctl0 = base0;
        if (wr_go && grp == G_C0) s_d.ctl0 = apply_op(op, base0, bus_wdata) & C0_MASK;

        c1 = s_q.ctl1;
        if (wr_go && grp == G_C1) c1 = apply_op(op, s_q.ctl1, bus_wdata) & C1_MASK;
        s_d.ctl1 = c1 | (32'(ch_done) & CH_MASK);

        c2 = s_q.ctl2;
        if (wr_go && grp == G_C2) c2 = apply_op(op, s_q.ctl2, bus_wdata) & C2_MASK;
        s_d.ctl2 = c2 | (32'(ch_err) & CH_MASK);

        if (wr_go && grp == G_NXT) s_d.nxt[chan] = bus_wdata;

        if (rd_go) begin
            case (grp)
                G_C0:    s_d.rdata = s_q.ctl0;
                G_C1:    s_d.rdata = s_q.ctl1;
                G_C2:    s_d.rdata = s_q.ctl2;
                G_NXT:   s_d.rdata = s_q.nxt[chan];
                G_SEMA:  s_d.rdata = 32'(sema_cnt[chan]) << SEMA_LSB;
                default: s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_en_w     = s_q.ctl1[IEN_LSB +: NCH];
    assign bus_rdata    = s_q.rdata;
    assign ch_gate      = s_q.ctl0[GATE_LSB +: NCH];
    assign ch_rst       = s_q.ctl0[RST_LSB +: NCH];
    assign burst8_en    = s_q.ctl0[BIT_BURST8];
    assign burst_en     = s_q.ctl0[BIT_BURST];
    assign ch_next_addr = s_q.nxt;
    assign irq          = (|(s_q.ctl1[NCH-1:0] & irq_en_w)) | (|s_q.ctl2[NCH-1:0]);

endmodule

// File: rtl/dmac_ctrl_regs_chk.sv
module dmac_ctrl_regs_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_sel,
    input logic           bus_wr,
    input logic [NCH-1:0] ch_done,
    input logic [NCH-1:0] ch_err,
    input logic [NCH-1:0] ch_dec,
    input logic [NCH-1:0] ch_gate,
    input logic [NCH-1:0] ch_rst,
    input logic [NCH-1:0] ch_run,
    input logic [NCH-1:0] irq_en,
    input logic           irq
);

    logic wr_go;
    assign wr_go = bus_sel && bus_wr;

    p_gate_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_gate) |-> $past(wr_go));

    p_rst_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_rst) |-> $past(wr_go));

    p_rst_self_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_rst) && !wr_go) |=> (ch_rst == '0));

    p_done_raises_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ch_done & irq_en)) && !wr_go) |=> irq);

    p_err_raises_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ch_err) && !wr_go) |=> irq);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|ch_done) || (|ch_err) || wr_go));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        p_run_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_run[n]) |-> $past(ch_dec[n]));

        p_run_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_run[n]) |-> $past(wr_go));
    end

endmodule

bind dmac_ctrl_regs dmac_ctrl_regs_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .ch_done (ch_done),
    .ch_err  (ch_err),
    .ch_dec  (ch_dec),
    .ch_gate (ch_gate),
    .ch_rst  (ch_rst),
    .ch_run  (ch_run),
    .irq_en  (irq_en_w),
    .irq     (irq)
);

// File: tb/dmac_ctrl_regs_test.sv
`timescale 1ns/1ps
module dmac_ctrl_regs_test;

    localparam int NCH = 8;
    localparam int AW  = 12;
    localparam real TCK = 8.0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    ch_done = '0;
    logic [NCH-1:0]    ch_err = '0;
    logic [NCH-1:0]    ch_dec = '0;
    logic [NCH-1:0]    ch_gate, ch_rst, ch_run;
    logic [NCH*32-1:0] ch_next_addr;
    logic              burst_en, burst8_en, irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(TCK/2) clk = ~clk;

    dmac_ctrl_regs #(.NCH(NCH), .AW(AW), .SEMA_W(8)) uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int addr, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(int addr, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = AW'(addr);
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic pulse(logic [NCH-1:0] dn, logic [NCH-1:0] er, logic [NCH-1:0] dc);
        @(negedge clk);
        ch_done = dn; ch_err = er; ch_dec = dc;
        @(negedge clk);
        ch_done = '0; ch_err = '0; ch_dec = '0;
    endtask

    task automatic wr_pulse(int addr, logic [31:0] d,
                            logic [NCH-1:0] dn, logic [NCH-1:0] er, logic [NCH-1:0] dc);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(addr); bus_wdata = d;
        ch_done = dn; ch_err = er; ch_dec = dc;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        ch_done = '0; ch_err = '0; ch_dec = '0;
    endtask

    initial begin
        #(TCK * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, c0, c1;
        int cnt;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 outs", {irq, burst_en, burst8_en, ch_gate, ch_rst, ch_run}, 0);
        chk("R1 nxt", 32'(|ch_next_addr), 0);
        for (int g = 0; g < 3; g++) begin
            rd(g * 16, r);
            chk("R1 global", r, 0);
        end

        // R3/R4: full write, unused bits drop, reset bits pulse
        wr(0, 32'hFFFF_FFFF);
        chk("R4 rst all pulse", 32'(ch_rst), 32'hFF);
        @(negedge clk);
        chk("R4 rst all clear", 32'(ch_rst), 0);
        c0 = 32'h3000_FF00;
        rd(0, r);
        chk("R3 ctl0 mask", r, c0);
        chk("R3 bursts", {burst8_en, burst_en}, 2'b11);
        // R2 clear / set aliases per gate bit
        for (int n = 0; n < NCH; n++) begin
            wr(8, 32'd1 << (8 + n));
            c0 &= ~(32'd1 << (8 + n));
            chk("R3 gate clr", 32'(ch_gate), (c0 >> 8) & 32'hFF);
        end
        wr(8, 32'h1000_0000);
        c0 = 32'h2000_0000;
        chk("R3 burst off", {burst8_en, burst_en}, 2'b10);
        for (int n = 0; n < NCH; n += 3) begin
            wr(4, 32'd1 << (8 + n));
            c0 |= 32'd1 << (8 + n);
            chk("R2 set alias", 32'(ch_gate), (c0 >> 8) & 32'hFF);
        end
        for (int a = 0; a < 3; a++) begin
            rd(a * 4, r);
            chk("R2 alias read", r, c0);
        end
        wr(0, 32'h0000_5A00);
        c0 = 32'h0000_5A00;
        rd(8, r);
        chk("R2 plain write", r, c0);

        // R4 per-channel reset pulse
        for (int n = 0; n < NCH; n++) begin
            wr(4, 32'd1 << (16 + n));
            chk("R4 pulse", 32'(ch_rst), 32'd1 << n);
            @(negedge clk);
            chk("R4 one cycle", 32'(ch_rst), 0);
        end
        rd(0, r);
        chk("R4 reads zero", r, c0);

        // R5/R7 completion flags
        wr(4 + 16, 32'h00FF_0000);
        c1 = 32'h00FF_0000;
        for (int n = 0; n < NCH; n++) begin
            pulse(NCH'(1) << n, 0, 0);
            chk("R7 irq on done", 32'(irq), 1);
            rd(16, r);
            chk("R5 sticky", r, c1 | (32'd1 << n));
            wr(16 + 8, 32'd1 << n);
            chk("R7 irq cleared", 32'(irq), 0);
        end
        wr_pulse(16 + 8, 32'h0000_0004, NCH'(4), 0, 0);
        rd(16, r);
        chk("R5 pulse beats clear", r, c1 | 32'h4);
        chk("R7 irq after collide", 32'(irq), 1);
        wr(16 + 8, 32'h0004_0004);
        c1 = 32'h00FB_0000;
        pulse(NCH'(4), 0, 0);
        chk("R7 masked", 32'(irq), 0);
        rd(16 + 4, r);
        chk("R5 masked still sticky", r, c1 | 32'h4);
        wr(16, 0);

        // R6 errors
        for (int n = 0; n < NCH; n++) begin
            pulse(0, NCH'(1) << n, 0);
            chk("R6 irq on err", 32'(irq), 1);
            rd(32, r);
            chk("R6 sticky", r, 32'd1 << n);
            wr(32 + 8, 32'd1 << n);
            chk("R6 cleared", 32'(irq), 0);
        end
        wr_pulse(32 + 8, 32'h80, 0, NCH'(8'h80), 0);
        rd(32, r);
        chk("R6 pulse beats clear", r, 32'h80);
        wr(32, 0);
        chk("R6 plain clear", 32'(irq), 0);

        // R8 next addresses
        for (int n = 0; n < NCH; n++)
            wr('h50 + n * 'h70, 32'hA500_0000 + 32'(n) * 32'h0101_0011);
        for (int n = 0; n < NCH; n++) begin
            r = 32'hA500_0000 + 32'(n) * 32'h0101_0011;
            chk("R8 port", ch_next_addr[n*32 +: 32], r);
            rd('h50 + n * 'h70, c1);
            chk("R8 read", c1, r);
        end

        // R9 credit counters
        for (int n = 0; n < NCH; n++) begin
            wr('h80 + n * 'h70, 32'(n + 1) << 16);
            chk("R9 run set", 32'(ch_run), (32'd2 << n) - 1);
        end
        for (int n = 0; n < NCH; n++) begin
            cnt = n + 1;
            for (int k = 0; k <= n + 1; k++) begin
                rd('h80 + n * 'h70, r);
                chk("R9 count", r, 32'(cnt) << 16);
                pulse(NCH'(1) << n, 0, NCH'(1) << n);
                if (cnt > 0) cnt--;
            end
            chk("R9 floor", 32'(ch_run[n]), 0);
        end
        rd(16, r);
        chk("R5 done from sweep", r, 32'hFF);
        wr(16 + 8, 32'hFF);
        wr('h80 + 3 * 'h70, 32'hFFC8_FFFF);
        wr('h80 + 3 * 'h70, 32'h00C8_0000);
        rd('h80 + 3 * 'h70, r);
        chk("R9 saturate", r, 32'h00FF_0000);
        wr('h80 + 5 * 'h70, 32'h0004_0000);
        wr_pulse('h80 + 5 * 'h70, 32'h0002_0000, 0, 0, NCH'(1) << 5);
        rd('h80 + 5 * 'h70, r);
        chk("R9 add and dec", r, 32'h0005_0000);

        // R10 unmapped
        for (int a = 0; a < 4; a++) begin
            int ua;
            ua = (a == 0) ? 'h0C : (a == 1) ? 'h54 : (a == 2) ? 'h3FC : 'h2C;
            wr(ua, 32'hFFFF_FFFF);
            rd(ua, r);
            chk("R10 unmapped read", r, 0);
        end
        rd(0, r);
        chk("R10 ctl0 untouched", r, c0);
        rd('h50, r);
        chk("R10 nxt untouched", r, 32'hA500_0000);
        chk("R10 irq untouched", 32'(irq), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule